// File: doc/BRIEF.md
# ALU Flags and Condition Evaluator

This block is the execute-stage core of a small 32-bit integer datapath. It takes two operands and an operation code, and it produces a result together with the negative, zero, carry and overflow status that result implies. A four-bit status register holds the most recently committed flags. A purely combinational predicate compares a four-bit condition code against those registered flags and reports whether the current instruction may take effect.

The predicate gates everything the instruction does. A failing condition suppresses the result write strobe and blocks any flag update. Compare only updates the flags and never asks for a result write. The logical operations refresh only N and Z. Shifting, multiplication and saturating arithmetic are handled elsewhere.

Top module: `alu_cond_unit`

## Requirements
- R1: Operation code 0 (ADD) returns opA+opB modulo 2^32. C is the carry out of bit 31 and V is signed overflow. For example, 0xFFFFFFFF+1 gives 0 with N=0 Z=1 C=1 V=0, and 0x7FFFFFFF+1 gives 0x80000000 with N=1 Z=0 C=1→0 V=1 (that is, C=0).
- R2: Operation code 1 (SUB) returns opA-opB, and C=1 means no borrow. For example, 10-5 gives flags 0010, 10-10 gives 0110, 10-20 gives 1000, and 0x80000000-1 gives 0x7FFFFFFF with flags 0011. Flags are written {N,Z,C,V}.
- R3: Operation code 2 (CMP) computes opA-opB with the same flags as SUB. It keeps `resultWrite` low, and it updates the flag register whenever its condition passes, even when `setFlags` is low.
- R4: Operation codes 3 (AND), 4 (ORR), 5 (EOR), 6 and 7 (MOV, result = opB) set N from result bit 31 and Z from a zero result. They leave C and V at their registered values.
- R5: After synchronous reset the flag register reads 0000. The `flags` port is {N,Z,C,V} with N at bit 3.
- R6: The flag register loads the next flags on a rising edge only when the condition passes and `setFlags` is high (or the operation is CMP). Otherwise it holds its value.
- R7: Condition codes 0 to 7 pass on, in turn: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R8: Condition codes 8 to 13 pass on, in turn: (C=1 and Z=0), (C=0 or Z=1), N==V, N!=V, (Z=0 and N==V), (Z=1 or N!=V).
- R9: Condition code 14 always passes and code 15 never passes. `condPass` depends only on `condCode` and the registered flags, in the same cycle.
- R10: `resultWrite` is high exactly when the condition passes and the operation is not CMP. `result` is valid combinationally in the same cycle as its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code (see R1 to R4) |
| setFlags | input | 1 | Request a flag update |
| condCode | input | 4 | Condition code (see R7 to R9) |
| result | output | 32 | Operation result |
| resultWrite | output | 1 | Result may be written back |
| condPass | output | 1 | Condition evaluated on registered flags |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
Three outputs are combinational and due in the same cycle as their inputs: `result`, `resultWrite` and `condPass`. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. The `flags` port reflects an update one rising edge later, so each flag check is sampled one nanosecond after that edge, while no further stimulus has been applied. Condition sweeps run with `setFlags` low and a non-compare operation, so the registered flags stay constant across the many edges of a sweep.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_ORR  = 3'd4,
    OP_EOR  = 3'd5,
    OP_MOV  = 3'd6,
    OP_MOV2 = 3'd7
  } aluOp_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } condCode_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_ORR  = 2'd1,
    LG_EOR  = 2'd2,
    LG_PASS = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      useArith;
    logic      subtract;
    logicSel_e logicSel;
  } dpStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dpStrobe_t          strobe,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  flags_t             curFlags,
  output logic [DATA_W-1:0]  result,
  output flags_t             nextFlags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bOperand;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] logicRes;
  logic              arithV;

  always_comb begin
    bOperand = strobe.subtract ? ~opB : opB;
    sumWide  = {1'b0, opA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, strobe.subtract};
    arithV   = (opA[MSB] == bOperand[MSB]) && (sumWide[MSB] != opA[MSB]);
  end

  always_comb begin
    unique case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_ORR:  logicRes = opA | opB;
      LG_EOR:  logicRes = opA ^ opB;
      default: logicRes = opB;
    endcase
  end

  always_comb begin
    result      = strobe.useArith ? sumWide[MSB:0] : logicRes;
    nextFlags.n = result[MSB];
    nextFlags.z = (result == '0);
    nextFlags.c = strobe.useArith ? sumWide[DATA_W] : curFlags.c;
    nextFlags.v = strobe.useArith ? arithV : curFlags.v;
  end

  // R1
  always_comb begin
    add_carry_chk: assert (!(strobe.useArith && !strobe.subtract)
                           || (nextFlags.c == (result < opA)));
  end

  // R2
  always_comb begin
    sub_borrow_chk: assert (!(strobe.useArith && strobe.subtract)
                            || (nextFlags.c == (opA >= opB)));
  end

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [2:0] opSel,
  input  logic      setFlags,
  input  logic [3:0] condCode,
  input  flags_t    nextFlags,
  output dpStrobe_t strobe,
  output flags_t    flagQ,
  output logic      condPass,
  output logic      resultWrite
);

  aluOp_e    opCode;
  condCode_e ccCode;
  logic      isCmp;
  logic      isLogic;
  logic      flagWe;

  always_comb begin
    opCode  = aluOp_e'(opSel);
    ccCode  = condCode_e'(condCode);
    isCmp   = (opCode == OP_CMP);
    isLogic = 1'b0;
    strobe  = '{useArith: 1'b1, subtract: 1'b0, logicSel: LG_PASS};
    unique case (opCode)
      OP_ADD:  strobe.subtract = 1'b0;
      OP_SUB,
      OP_CMP:  strobe.subtract = 1'b1;
      OP_AND:  begin strobe.useArith = 1'b0; strobe.logicSel = LG_AND; isLogic = 1'b1; end
      OP_ORR:  begin strobe.useArith = 1'b0; strobe.logicSel = LG_ORR; isLogic = 1'b1; end
      OP_EOR:  begin strobe.useArith = 1'b0; strobe.logicSel = LG_EOR; isLogic = 1'b1; end
      default: begin strobe.useArith = 1'b0; strobe.logicSel = LG_PASS; isLogic = 1'b1; end
    endcase
  end

  always_comb begin
    unique case (ccCode)
      CC_EQ:   condPass = flagQ.z;
      CC_NE:   condPass = !flagQ.z;
      CC_CS:   condPass = flagQ.c;
      CC_CC:   condPass = !flagQ.c;
      CC_MI:   condPass = flagQ.n;
      CC_PL:   condPass = !flagQ.n;
      CC_VS:   condPass = flagQ.v;
      CC_VC:   condPass = !flagQ.v;
      CC_HI:   condPass = flagQ.c && !flagQ.z;
      CC_LS:   condPass = !flagQ.c || flagQ.z;
      CC_GE:   condPass = (flagQ.n == flagQ.v);
      CC_LT:   condPass = (flagQ.n != flagQ.v);
      CC_GT:   condPass = !flagQ.z && (flagQ.n == flagQ.v);
      CC_LE:   condPass = flagQ.z || (flagQ.n != flagQ.v);
      CC_AL:   condPass = 1'b1;
      default: condPass = 1'b0;
    endcase
  end

  assign flagWe      = condPass && (setFlags || isCmp);
  assign resultWrite = condPass && !isCmp;

  always_ff @(posedge clk) begin
    if (rst)         flagQ <= '0;
    else if (flagWe) flagQ <= nextFlags;
  end

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flagWe |=> $stable(flagQ));

  // R4
  logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (flagWe && isLogic) |=> (flagQ.c == $past(flagQ.c)) && (flagQ.v == $past(flagQ.v)));

endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  input  logic              setFlags,
  input  logic [3:0]        condCode,
  output logic [DATA_W-1:0] result,
  output logic              resultWrite,
  output logic              condPass,
  output logic [3:0]        flags
);

  dpStrobe_t dpStrobe;
  flags_t    flagQ;
  flags_t    nextFlags;

  alu_control u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .opSel       (opSel),
    .setFlags    (setFlags),
    .condCode    (condCode),
    .nextFlags   (nextFlags),
    .strobe      (dpStrobe),
    .flagQ       (flagQ),
    .condPass    (condPass),
    .resultWrite (resultWrite)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe    (dpStrobe),
    .opA       (opA),
    .opB       (opB),
    .curFlags  (flagQ),
    .result    (result),
    .nextFlags (nextFlags)
  );

  assign flags = flagQ;

  // R3
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (opSel == 3'd2) |-> !resultWrite);

  // R9
  always_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (condCode == 4'd14) |-> condPass);

  // R9
  never_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (condCode == 4'd15) |-> !condPass);

endmodule

// File: tb/sim_alu_cond_unit.sv
`timescale 1ns/1ps
module sim_alu_cond_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = 3'd0;
  logic        setFlags = 1'b0;
  logic [3:0]  condCode = 4'd14;
  logic [31:0] result;
  logic        resultWrite;
  logic        condPass;
  logic [3:0]  flags;

  int testsRun = 0;
  int testsFailed = 0;
  logic [3:0] modelFlags = 4'b0000;

  always #2.5 clk = ~clk;

  alu_cond_unit u0 (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opSel(opSel),
    .setFlags(setFlags), .condCode(condCode), .result(result),
    .resultWrite(resultWrite), .condPass(condPass), .flags(flags)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expectPass(logic [3:0] f, logic [3:0] code);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // drive at falling edge, combinational outputs sampled 1 ns later
  task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] op, logic sf, logic [3:0] cc);
    @(negedge clk);
    opA = a; opB = b; opSel = op; setFlags = sf; condCode = cc;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    setFlags = 1'b0; opSel = 3'd0; condCode = 4'd14;
    #1;
  endtask

  // one op with AL and flag update; checks result now, flags after the edge
  task automatic runOp(string tag, logic [31:0] a, logic [31:0] b, logic [2:0] op,
                       logic [31:0] expRes, logic [3:0] expFlags);
    drive(a, b, op, 1'b1, 4'd14);
    check({tag, " result"}, result, expRes);
    check({tag, " resultWrite"}, {31'd0, resultWrite}, {31'd0, op != 3'd2});
    @(posedge clk); #1;
    check({tag, " flags"}, {28'd0, flags}, {28'd0, expFlags});
    modelFlags = expFlags;
    idle();
  endtask

  task automatic condSweep(string tag);
    for (int code = 0; code < 16; code++) begin
      condCode = code[3:0];
      #1;
      check($sformatf("%s %s code %0d", code < 8 ? "R7" : (code < 14 ? "R8" : "R9"), tag, code),
            {31'd0, condPass}, {31'd0, expectPass(modelFlags, code[3:0])});
      check($sformatf("R10 %s code %0d resultWrite", tag, code),
            {31'd0, resultWrite}, {31'd0, expectPass(modelFlags, code[3:0])});
    end
    condCode = 4'd14;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    check("R5 reset flags", {28'd0, flags}, 32'd0);
    modelFlags = 4'b0000;
    condSweep("after reset");
  endtask

  task automatic testAdd();
    runOp("R1 add small", 32'd3, 32'd4, 3'd0, 32'd7, 4'b0000);
    runOp("R1 add wrap", 32'hFFFF_FFFF, 32'd1, 3'd0, 32'd0, 4'b0110);
    condSweep("Z C set");
    runOp("R1 add ovf", 32'h7FFF_FFFF, 32'd1, 3'd0, 32'h8000_0000, 4'b1001);
    condSweep("N V set");
  endtask

  task automatic testSub();
    runOp("R2 sub 10-5", 32'd10, 32'd5, 3'd1, 32'd5, 4'b0010);
    condSweep("C only");
    runOp("R2 sub 10-10", 32'd10, 32'd10, 3'd1, 32'd0, 4'b0110);
    runOp("R2 sub 10-20", 32'd10, 32'd20, 3'd1, 32'hFFFF_FFF6, 4'b1000);
    condSweep("N only");
    runOp("R2 sub ovf", 32'h8000_0000, 32'd1, 3'd1, 32'h7FFF_FFFF, 4'b0011);
    condSweep("C V set");
  endtask

  task automatic testLogic();
    // flags are 0011 here: C and V must survive
    runOp("R4 and", 32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'd3, 32'd0, 4'b0111);
    runOp("R4 orr", 32'h8000_0000, 32'd1, 3'd4, 32'h8000_0001, 4'b1011);
    runOp("R4 eor", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd5, 32'd0, 4'b0111);
    runOp("R4 mov", 32'hDEAD_BEEF, 32'h1234_5678, 3'd6, 32'h1234_5678, 4'b0011);
    runOp("R4 mov alt", 32'd0, 32'h8000_0000, 3'd7, 32'h8000_0000, 4'b1011);
  endtask

  task automatic testGating();
    runOp("R6 prep", 32'd10, 32'd10, 3'd1, 32'd0, 4'b0110);
    // setFlags low, condition passes: flags hold
    drive(32'd1, 32'd1, 3'd0, 1'b0, 4'd14);
    check("R10 add no sf write", {31'd0, resultWrite}, 32'd1);
    @(posedge clk); #1;
    check("R6 hold without setFlags", {28'd0, flags}, 32'b0110);
    // NE fails (Z=1): no write, no flag update
    drive(32'd1, 32'd1, 3'd0, 1'b1, 4'd1);
    check("R10 failed cond no write", {31'd0, resultWrite}, 32'd0);
    check("R6 failed cond pass", {31'd0, condPass}, 32'd0);
    @(posedge clk); #1;
    check("R6 hold on failed cond", {28'd0, flags}, 32'b0110);
    // CMP with setFlags low still updates flags, never writes result
    drive(32'd5, 32'd10, 3'd2, 1'b0, 4'd14);
    check("R3 cmp result", result, 32'hFFFF_FFFB);
    check("R3 cmp no write", {31'd0, resultWrite}, 32'd0);
    @(posedge clk); #1;
    check("R3 cmp flags", {28'd0, flags}, 32'b1000);
    modelFlags = 4'b1000;
    // CMP under failing condition (EQ, Z=0): flags hold
    drive(32'd7, 32'd7, 3'd2, 1'b1, 4'd0);
    @(posedge clk); #1;
    check("R3 cmp failed cond hold", {28'd0, flags}, 32'b1000);
    // NV never passes, even with setFlags
    drive(32'd7, 32'd7, 3'd1, 1'b1, 4'd15);
    check("R9 nv no write", {31'd0, resultWrite}, 32'd0);
    @(posedge clk); #1;
    check("R9 nv flags hold", {28'd0, flags}, 32'b1000);
    idle();
    // synchronous reset clears flags
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R5 reset clears", {28'd0, flags}, 32'd0);
    @(negedge clk); rst = 1'b0;
    modelFlags = 4'b0000;
  endtask

  initial begin
    testReset();
    testAdd();
    testSub();
    testLogic();
    testGating();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule